// File: doc/BRIEF.md
# Banked Register File Controller

This block is the data-memory unit of a small 8-bit controller core. It keeps general-purpose RAM together with two core special registers, a status register and a pointer register, spread over four banks, and it turns every access into one physical location. The core hands it a 7-bit offset taken from the instruction, a flag that forces pointer-based access, read and write strobes, and write data. The block returns read data and shows the live status and pointer values to the rest of the core.

A direct access builds its physical address from the two bank bits of the status register and the 7-bit offset. An indirect access builds it from the pair-select bit of the status register and the full 8-bit pointer. Offsets 0x70 to 0x7F form a common region that reaches the same storage from every bank. The status and pointer registers appear at the same offset in every bank. Offset 0 is a data port that forwards the access through the pointer.

On reset only the status register takes a defined value. The pointer and all general RAM keep what they held.

Top module: `banked_regfile`

## Requirements
- R1: A direct access (indirect flag low, offset not 0) reaches physical address {status[6], status[5], offset}. The same offset therefore reaches separate storage in each of the four banks.
- R2: An access is indirect when the indirect flag is high or the offset is 0. It reaches physical address {status[7], pointer[7:0]}, where the low 7 bits of that address act as the offset.
- R3: Any resolved offset from 0x70 to 0x7F, direct or indirect, reaches the same byte whatever the bank bits are.
- R4: The status register sits at offset 3 and the pointer register at offset 4 in every bank. Reads and writes reach them in every bank and through the pointer.
- R5: An indirect access whose resolved offset is 0 reads 0x00, and its write changes no storage, status or pointer.
- R6: Reset sets the status register to 0x18. The pointer register and all general RAM keep their contents through reset.
- R7: Read data follows the resolved address combinationally while the read strobe is high and is 0x00 while it is low. A write takes effect at the rising clock edge on which the write strobe is high, and no register changes without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ofs_i | input | 7 | Offset field from the instruction |
| ind_i | input | 1 | Forces a pointer-based (indirect) access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, zero when not reading |
| status_o | output | 8 | Current status register |
| ptr_o | output | 8 | Current pointer register |

## Verification
The same offset 0x20 is written with a different value in each of the four banks and read back under changing bank bits. A wrong bank-bit choice therefore returns another bank's value instead of a plain miss. The pointer tests first aim it at a location in another bank and then change the pair-select bit. This separates the pair-select bit from the direct bank bits. Accesses to the common region go through both direct and indirect paths, so a missing alias shows up. Further tests aim the pointer at the status register and at the data port itself, write through it, and reset with live state to show what survives.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
    localparam int DATA_W    = 8;
    localparam int OFS_W     = 7;
    localparam int BANK_BITS = 2;
    localparam int PHYS_W    = OFS_W + BANK_BITS;
    localparam int RAM_DEPTH = 2 ** PHYS_W;

    // status bit positions used for address formation
    localparam int SEL_HALF_BIT = 7;
    localparam int SEL_HI_BIT   = 6;
    localparam int SEL_LO_BIT   = 5;

    localparam logic [OFS_W-1:0]  OFS_PORT   = 7'h00;
    localparam logic [OFS_W-1:0]  OFS_STATUS = 7'h03;
    localparam logic [OFS_W-1:0]  OFS_PTR    = 7'h04;
    localparam logic [OFS_W-1:0]  COMMON_LO  = 7'h70;
    localparam logic [DATA_W-1:0] STATUS_RST = 8'h18;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_STATUS,
        TGT_PTR,
        TGT_RAM
    } tgt_e;

    typedef struct packed {
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] ptr;
    } core_regs_t;
endpackage

// File: rtl/rfc_resolve.sv
module rfc_resolve
    import rfc_pkg::*;
(
    input  logic              ind_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] ptr_i,
    output tgt_e              tgt_o,
    output logic [PHYS_W-1:0] ram_addr_o
);
    logic              use_ptr;
    logic [PHYS_W-1:0] phys;
    logic [OFS_W-1:0]  loc_ofs;

    always_comb begin
        use_ptr = ind_i || (ofs_i == OFS_PORT);
        if (use_ptr) begin
            phys = {status_i[SEL_HALF_BIT], ptr_i};
        end else begin
            phys = {status_i[SEL_HI_BIT], status_i[SEL_LO_BIT], ofs_i};
        end
        loc_ofs = phys[OFS_W-1:0];

        unique case (loc_ofs)
            OFS_PORT:   tgt_o = TGT_NONE;
            OFS_STATUS: tgt_o = TGT_STATUS;
            OFS_PTR:    tgt_o = TGT_PTR;
            default:    tgt_o = TGT_RAM;
        endcase

        if (loc_ofs >= COMMON_LO) begin
            ram_addr_o = {{BANK_BITS{1'b0}}, loc_ofs};
        end else begin
            ram_addr_o = phys;
        end
    end
endmodule

// File: rtl/rfc_gpr.sv
module rfc_gpr
    import rfc_pkg::*;
(
    input  logic              clk,
    input  logic              we_i,
    input  logic [PHYS_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem_q [RAM_DEPTH];

    // no reset: contents survive every reset
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/rfc_core_regs.sv
module rfc_core_regs
    import rfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_status_i,
    input  logic              wr_ptr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] status_o,
    output logic [DATA_W-1:0] ptr_o
);
    core_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_status_i) begin
            regs_d.status = wdata_i;
        end
        if (wr_ptr_i) begin
            regs_d.ptr = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.status <= STATUS_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign status_o = regs_q.status;
    assign ptr_o    = regs_q.ptr;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        ofs_i,
    input  logic              ind_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic [7:0]        status_o,
    output logic [7:0]        ptr_o
);
    tgt_e              tgt;
    logic [PHYS_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_rdata;
    logic              ram_we;
    logic              wr_status;
    logic              wr_ptr;
    logic [DATA_W-1:0] sel_data;

    rfc_resolve u_resolve (
        .ind_i      (ind_i),
        .ofs_i      (ofs_i),
        .status_i   (status_o),
        .ptr_i      (ptr_o),
        .tgt_o      (tgt),
        .ram_addr_o (ram_addr)
    );

    always_comb begin
        ram_we    = wr_i && (tgt == TGT_RAM);
        wr_status = wr_i && (tgt == TGT_STATUS);
        wr_ptr    = wr_i && (tgt == TGT_PTR);
        unique case (tgt)
            TGT_STATUS: sel_data = status_o;
            TGT_PTR:    sel_data = ptr_o;
            TGT_RAM:    sel_data = ram_rdata;
            default:    sel_data = '0;
        endcase
        rdata_o = rd_i ? sel_data : '0;
    end

    rfc_gpr u_gpr (
        .clk     (clk),
        .we_i    (ram_we),
        .addr_i  (ram_addr),
        .wdata_i (wdata_i),
        .rdata_o (ram_rdata)
    );

    rfc_core_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_status_i (wr_status),
        .wr_ptr_i    (wr_ptr),
        .wdata_i     (wdata_i),
        .status_o    (status_o),
        .ptr_o       (ptr_o)
    );
endmodule

// File: rtl/rfc_checker.sv
module rfc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] ofs_i,
    input logic       ind_i,
    input logic       rd_i,
    input logic       wr_i,
    input logic [7:0] wdata_i,
    input logic [7:0] rdata_o,
    input logic [7:0] status_o,
    input logic [7:0] ptr_o
);
    logic via_ptr;
    logic self_hit;
    assign via_ptr  = ind_i || (ofs_i == 7'h00);
    assign self_hit = via_ptr && (ptr_o[6:0] == 7'h00);

    assert_status_reset_R6: assert property (@(posedge clk)
        !rst_n |=> (status_o == 8'h18));

    assert_idle_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |-> (rdata_o == 8'h00));

    assert_ptr_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(ptr_o));

    assert_self_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && self_hit) |-> (rdata_o == 8'h00));

    assert_self_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && self_hit) |=> ($stable(status_o) && $stable(ptr_o)));

    assert_status_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !ind_i && ofs_i == 7'h03) |-> (rdata_o == status_o));

    assert_ptr_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !ind_i && ofs_i == 7'h04) |=> (ptr_o == $past(wdata_i)));
endmodule

bind banked_regfile rfc_checker u_rfc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ofs_i    (ofs_i),
    .ind_i    (ind_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .status_o (status_o),
    .ptr_o    (ptr_o)
);

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] ofs_i = '0;
    logic       ind_i = 1'b0;
    logic       rd_i = 1'b0;
    logic       wr_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o, status_o, ptr_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    banked_regfile u_banked_regfile (
        .clk(clk), .rst_n(rst_n), .ofs_i(ofs_i), .ind_i(ind_i),
        .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .status_o(status_o), .ptr_o(ptr_o)
    );

    typedef struct packed {
        logic       ind;
        logic [6:0] ofs;
        logic       wr;
        logic [7:0] dat;   // write data, or expected read data
        logic [3:0] req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 7'h20, 1'b1, 8'h11, 4'd1},  // bank0 0x20
        '{1'b0, 7'h03, 1'b1, 8'h38, 4'd1},  // select bank1
        '{1'b0, 7'h20, 1'b1, 8'h22, 4'd1},
        '{1'b0, 7'h03, 1'b1, 8'h58, 4'd1},  // bank2
        '{1'b0, 7'h20, 1'b1, 8'h33, 4'd1},
        '{1'b0, 7'h03, 1'b1, 8'h78, 4'd1},  // bank3
        '{1'b0, 7'h20, 1'b1, 8'h44, 4'd1},
        '{1'b0, 7'h20, 1'b0, 8'h44, 4'd1},  // R1 read bank3
        '{1'b0, 7'h70, 1'b1, 8'h55, 4'd3},  // common write from bank3
        '{1'b0, 7'h03, 1'b1, 8'h18, 4'd4},  // back to bank0
        '{1'b0, 7'h20, 1'b0, 8'h11, 4'd1},  // R1 read bank0
        '{1'b0, 7'h70, 1'b0, 8'h55, 4'd3},  // R3 common from bank0
        '{1'b0, 7'h03, 1'b0, 8'h18, 4'd4},  // R4 status read
        '{1'b0, 7'h04, 1'b1, 8'hA0, 4'd4},  // pointer -> phys 0x0A0
        '{1'b1, 7'h55, 1'b0, 8'h22, 4'd2},  // R2 flag-driven indirect
        '{1'b0, 7'h04, 1'b0, 8'hA0, 4'd4},  // R4 pointer read
        '{1'b0, 7'h03, 1'b1, 8'h98, 4'd2},  // upper half, bank0
        '{1'b0, 7'h00, 1'b0, 8'h44, 4'd2},  // R2 port -> phys 0x1A0
        '{1'b0, 7'h20, 1'b0, 8'h11, 4'd1},  // direct still bank0
        '{1'b0, 7'h04, 1'b1, 8'hF5, 4'd3},  // pointer -> offset 0x75
        '{1'b1, 7'h00, 1'b1, 8'h66, 4'd3},  // indirect common write
        '{1'b0, 7'h03, 1'b1, 8'h18, 4'd4},
        '{1'b0, 7'h75, 1'b0, 8'h66, 4'd3},  // R3 direct sees it
        '{1'b0, 7'h04, 1'b1, 8'h03, 4'd4},  // pointer -> status
        '{1'b1, 7'h00, 1'b0, 8'h18, 4'd4},  // R4 status via pointer
        '{1'b0, 7'h04, 1'b1, 8'h80, 4'd5},  // pointer -> port of bank1
        '{1'b1, 7'h00, 1'b1, 8'h77, 4'd5},  // discarded write
        '{1'b1, 7'h00, 1'b0, 8'h00, 4'd5},  // R5 reads zero
        '{1'b0, 7'h04, 1'b0, 8'h80, 4'd5},  // R5 pointer unchanged
        '{1'b0, 7'h03, 1'b0, 8'h18, 4'd5}   // R5 status unchanged
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic ind, input logic [6:0] ofs, input logic [7:0] d);
        @(negedge clk);
        ind_i = ind; ofs_i = ofs; wdata_i = d; wr_i = 1'b1; rd_i = 1'b0;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic do_rd(input logic ind, input logic [6:0] ofs, output logic [7:0] d);
        @(negedge clk);
        ind_i = ind; ofs_i = ofs; rd_i = 1'b1; wr_i = 1'b0;
        #1 d = rdata_o;
        @(negedge clk);
        rd_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 status after reset", status_o, 8'h18);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 idle read is zero", rdata_o, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                do_wr(VECS[i].ind, VECS[i].ofs, VECS[i].dat);
            end else begin
                do_rd(VECS[i].ind, VECS[i].ofs, r);
                check($sformatf("R%0d vector %0d", VECS[i].req, i), r, VECS[i].dat);
            end
        end

        // R7: write visible right after its edge, not before
        @(negedge clk);
        ind_i = 1'b0; ofs_i = 7'h30; wdata_i = 8'h9C; rd_i = 1'b1; wr_i = 1'b1;
        @(posedge clk);
        #1 check("R7 read after write edge", rdata_o, 8'h9C);
        @(negedge clk);
        wr_i = 1'b0; rd_i = 1'b0;
        #1 check("R7 read strobe low", rdata_o, 8'h00);

        // R6: reset with live state
        do_wr(1'b0, 7'h04, 8'h42);
        do_wr(1'b0, 7'h03, 8'h38);
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R6 status reset", status_o, 8'h18);
        check("R6 pointer retained", ptr_o, 8'h42);
        @(negedge clk);
        rst_n = 1'b1;
        do_rd(1'b0, 7'h30, r);
        check("R6 RAM retained", r, 8'h9C);
        do_rd(1'b0, 7'h20, r);
        check("R6 RAM bank0 retained", r, 8'h11);

        finish_run();
    end
endmodule